// File: doc/BRIEF.md
# Double-Buffered Serial DAC Code Loader

This block is the digital front end of a 16-bit voltage-output converter. A host writes a code word over a three-wire slave port (active-low select, serial clock, serial data). Bits are captured most significant first into a shift register. The rising edge of the select line copies that register into an input register. A second stage, the converter latch, drives the code that the analog section would convert. Everything runs in one system clock domain. Each port pin passes through a synchronizer, and edges are detected on the synchronized copies, so the system clock must run at least four times faster than the serial clock.

The update policy of the converter latch is chosen by a parameter. In immediate mode the latch follows the input register as soon as the input register is written. In strobe mode an active-low load strobe copies the input register into the latch. The shift register has no reset. A frame with fewer than sixteen clocks therefore keeps stale bits, and a frame with more than sixteen keeps the most recent sixteen. Two sticky flags are provided: one reports short frames and one reports a load strobe issued during a frame. A one-cycle pulse marks every write of the latch.

Top module: `dac_serial_loader`

## Requirements
- R1: After reset, `code_out` is 0, and `update_pulse`, `short_frame` and `proto_err` are all 0.
- R2: While `cs_n` is high, activity on `sclk` and `sdi` leaves the shift register unchanged. This is observable through the word that a later frame transfers.
- R3: Each rising edge of `sclk` while `cs_n` is low shifts `sdi` into bit 0 and moves the earlier bits toward bit 15. A 16-clock frame therefore transfers the first bit sent as bit 15.
- R4: In a frame of more than 16 clocks, the last 16 bits captured are transferred.
- R5: In a frame of k < 16 clocks, the transferred word is the previous shift register contents shifted left by k, with the k new bits in the low positions.
- R6: In immediate mode, `code_out` takes the new word on the third system clock edge after the first edge that samples `cs_n` high.
- R7: In strobe mode, `code_out` keeps its value across the end of a frame. It loads the input register on the third system clock edge after the first edge that samples `load_n` low while `cs_n` is high.
- R8: In strobe mode, with `load_n` held low, `code_out` updates at the end of each frame with the R6 timing.
- R9: A falling edge of `load_n` while `cs_n` is low does not change `code_out` and sets `proto_err`. `proto_err` stays set until reset.
- R10: `short_frame` is set at the end of a frame of fewer than 16 clocks and cleared at the end of a frame of 16 or more clocks.
- R11: `update_pulse` is high for exactly the one cycle in which `code_out` shows a newly written value, once per write, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select from host |
| sclk | input | 1 | Serial clock from host, idle low |
| sdi | input | 1 | Serial data, sampled on `sclk` rising edge |
| load_n | input | 1 | Active-low latch load strobe (strobe mode) |
| code_out | output | 16 | Converter latch code |
| update_pulse | output | 1 | One-cycle pulse on each latch write |
| short_frame | output | 1 | Sticky flag: last frame had fewer than 16 clocks |
| proto_err | output | 1 | Sticky flag: load strobe fell during a frame |

## Verification
The assertions assume that every pin holds each level for at least three system clocks. They also assume that a serial clock rising edge never falls in the same synchronized cycle as a select edge. Under those conditions one edge of each signal is seen per transition, and frame starts and data captures never collide. The stimulus keeps every serial clock phase three system clocks long and leaves three clocks of margin around each select edge. It also sends a full frame first, so the never-reset shift register holds a defined value before any short frame is sent.

// File: rtl/dacld_pkg.sv
package dacld_pkg;
   typedef enum logic {
      UPD_IMMEDIATE = 1'b0,
      UPD_STROBE    = 1'b1
   } upd_mode_e;
endpackage

// File: rtl/dacld_sync.sv
module dacld_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dacld_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dacld_shifter.sv
module dacld_shifter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cs_lo,
   input  logic         cs_fall,
   input  logic         cs_rise,
   input  logic         sclk_rise,
   input  logic         sdi,
   output logic [W-1:0] word,
   output logic         short_frame
);
   localparam int CNT_W = $clog2(W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

   logic [W-1:0]     sr_q;
   logic [CNT_W-1:0] cnt_q;
   logic             short_q;
   logic             take;

   assign take = sclk_rise && cs_lo;

   // Shift register has no reset: stale bits survive short frames.
   always_ff @(posedge clk) begin
      if (take) sr_q <= {sr_q[W-2:0], sdi};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         short_q <= 1'b0;
      end else begin
         if (cs_fall)                   cnt_q <= '0;
         else if (take && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
         if (cs_rise) short_q <= (cnt_q != FULL);
      end
   end

   assign word        = sr_q;
   assign short_frame = short_q;

   // R4
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL);

   // R10
   short_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(short_q) |-> $past(cs_rise));
endmodule

// File: rtl/dacld_latch.sv
module dacld_latch
   import dacld_pkg::*;
#(
   parameter int        W    = 16,
   parameter upd_mode_e MODE = UPD_STROBE
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         xfer,
   input  logic [W-1:0] word,
   input  logic         cs_hi,
   input  logic         ld_fall,
   input  logic         ld_lo,
   output logic [W-1:0] code,
   output logic         upd
);
   logic [W-1:0] in_q, code_q, wdata;
   logic         upd_q, wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    in_q <= '0;
      else if (xfer) in_q <= word;
   end

   if (MODE == UPD_IMMEDIATE) begin : g_imm
      assign wr    = xfer;
      assign wdata = word;

      // R6
      imm_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         xfer |=> upd);
   end else begin : g_strobe
      assign wr    = (ld_fall && cs_hi) || (ld_lo && xfer);
      assign wdata = xfer ? word : in_q;

      // R7
      strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (xfer && !ld_lo) |=> !upd);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         upd_q  <= 1'b0;
      end else begin
         upd_q <= wr;
         if (wr) code_q <= wdata;
      end
   end

   assign code = code_q;
   assign upd  = upd_q;

   // R11
   code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_q |-> $stable(code_q));

   // R9
   midframe_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_fall && !cs_hi) |=> !upd_q);

   // R8
   held_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && ld_lo) |=> upd_q);
endmodule

// File: rtl/dac_serial_loader.sv
module dac_serial_loader
   import dacld_pkg::*;
#(
   parameter int        DATA_W      = 16,
   parameter int        SYNC_STAGES = 2,
   parameter upd_mode_e UPD_MODE    = UPD_STROBE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdi,
   input  logic              load_n,
   output logic [DATA_W-1:0] code_out,
   output logic              update_pulse,
   output logic              short_frame,
   output logic              proto_err
);
   if (DATA_W < 2) begin : g_bad_width
      $error("dac_serial_loader: DATA_W must be at least 2");
   end

   logic cs_s, sclk_s, sdi_s, ld_s;
   logic cs_p, sclk_p, ld_p;
   logic cs_rise, cs_fall, sclk_rise, ld_fall;
   logic perr_q;
   logic [DATA_W-1:0] sr_word;

   dacld_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));
   dacld_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
   dacld_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
      .clk(clk), .rst_n(rst_n), .d(sdi), .q(sdi_s));
   dacld_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ld (
      .clk(clk), .rst_n(rst_n), .d(load_n), .q(ld_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_p   <= 1'b1;
         sclk_p <= 1'b0;
         ld_p   <= 1'b1;
      end else begin
         cs_p   <= cs_s;
         sclk_p <= sclk_s;
         ld_p   <= ld_s;
      end
   end

   assign cs_rise   =  cs_s   & ~cs_p;
   assign cs_fall   = ~cs_s   &  cs_p;
   assign sclk_rise =  sclk_s & ~sclk_p;
   assign ld_fall   = ~ld_s   &  ld_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 perr_q <= 1'b0;
      else if (ld_fall && !cs_s)  perr_q <= 1'b1;
   end
   assign proto_err = perr_q;

   dacld_shifter #(.W(DATA_W)) u_shifter (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_lo      (~cs_s),
      .cs_fall    (cs_fall),
      .cs_rise    (cs_rise),
      .sclk_rise  (sclk_rise),
      .sdi        (sdi_s),
      .word       (sr_word),
      .short_frame(short_frame)
   );

   dacld_latch #(.W(DATA_W), .MODE(UPD_MODE)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .xfer   (cs_rise),
      .word   (sr_word),
      .cs_hi  (cs_s),
      .ld_fall(ld_fall),
      .ld_lo  (~ld_s),
      .code   (code_out),
      .upd    (update_pulse)
   );

   // R9
   perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(perr_q));
endmodule

// File: tb/dac_serial_loader_bench.sv
module dac_serial_loader_bench;
   import dacld_pkg::*;

   localparam int W = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, load_n = 1'b1;
   logic [W-1:0] code_s, code_i;
   logic upd_s, upd_i, short_s, short_i, perr_s, perr_i;

   always #4 clk = ~clk;

   dac_serial_loader #(.DATA_W(W), .UPD_MODE(UPD_STROBE)) u_dac_serial_loader (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
      .load_n(load_n), .code_out(code_s), .update_pulse(upd_s),
      .short_frame(short_s), .proto_err(perr_s));

   dac_serial_loader #(.DATA_W(W), .UPD_MODE(UPD_IMMEDIATE)) u_dac_serial_loader_imm (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
      .load_n(load_n), .code_out(code_i), .update_pulse(upd_i),
      .short_frame(short_i), .proto_err(perr_i));

   int checks = 0, errors = 0;
   int pulses_s = 0, pulses_i = 0;

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   typedef struct packed { logic cs; logic sc; logic sd; logic ld; } pins_t;
   localparam pins_t IDLE = '{cs: 1'b1, sc: 1'b0, sd: 1'b0, ld: 1'b1};
   pins_t h1 = IDLE, h2 = IDLE, h3 = IDLE;
   logic [W-1:0] m_sr = 'x, m_in = '0, m_code_s = '0, m_code_i = '0;
   logic m_upd_s = 0, m_upd_i = 0, m_short = 0, m_perr = 0;
   int   m_cnt = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         h1 = IDLE; h2 = IDLE; h3 = IDLE;
         m_in = '0; m_code_s = '0; m_code_i = '0;
         m_upd_s = 0; m_upd_i = 0; m_short = 0; m_perr = 0; m_cnt = 0;
      end else begin
         bit cs_up, cs_dn, sc_up, ld_dn, cs_high, ld_low;
         logic [W-1:0] old_sr;
         cs_high = h2.cs; ld_low = !h2.ld;
         cs_up = h2.cs && !h3.cs;  cs_dn = !h2.cs && h3.cs;
         sc_up = h2.sc && !h3.sc;  ld_dn = !h2.ld && h3.ld;
         old_sr = m_sr;
         m_upd_s = 0; m_upd_i = 0;
         if (cs_up) begin
            m_in = old_sr;
            m_short = (m_cnt < W);
            m_code_i = old_sr; m_upd_i = 1;
         end
         if (ld_dn && !cs_high) m_perr = 1;
         if ((ld_dn && cs_high) || (ld_low && cs_up)) begin
            m_code_s = m_in; m_upd_s = 1;
         end
         if (cs_dn) m_cnt = 0;
         if (sc_up && !cs_high) begin
            m_sr = {old_sr[W-2:0], h2.sd};
            if (!cs_dn && m_cnt < W) m_cnt++;
         end
         h3 = h2; h2 = h1;
         h1 = '{cs: cs_n, sc: sclk, sd: sdi, ld: load_n};
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R7",  "strobe code",   code_s,  m_code_s);
         chk("R6",  "immediate code", code_i, m_code_i);
         chk("R11", "strobe pulse",  upd_s,   m_upd_s);
         chk("R11", "immediate pulse", upd_i, m_upd_i);
         chk("R10", "short flag",    {short_s, short_i}, {2{m_short}});
         chk("R9",  "proto flag",    {perr_s, perr_i},   {2{m_perr}});
         if (upd_s) pulses_s++;
         if (upd_i) pulses_i++;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wait_clk(int n); repeat (n) @(negedge clk); endtask

   task automatic frame_open(); cs_n = 1'b0; wait_clk(3); endtask

   task automatic shift_bits(logic [31:0] v, int n);
      for (int i = n - 1; i >= 0; i--) begin
         sdi = v[i]; wait_clk(3);
         sclk = 1'b1; wait_clk(3);
         sclk = 1'b0;
      end
   endtask

   task automatic frame_close(); wait_clk(3); cs_n = 1'b1; wait_clk(8); endtask

   task automatic send(logic [31:0] v, int n);
      frame_open(); shift_bits(v, n); frame_close();
   endtask

   task automatic strobe();
      load_n = 1'b0; wait_clk(3); load_n = 1'b1; wait_clk(8);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int p0;
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(2);
      // R1 reset state
      chk("R1", "code after reset", {code_s, code_i}, 32'h0);
      chk("R1", "flags after reset", {upd_s, upd_i, short_s, short_i, perr_s, perr_i}, 32'h0);

      // R3 full frame, R7 strobe latch holds
      send(32'hA5C3, 16);
      chk("R3", "full frame word", code_i, 16'hA5C3);
      chk("R7", "strobe latch holds", code_s, 16'h0000);
      p0 = pulses_s;
      strobe();
      chk("R7", "strobe loads", code_s, 16'hA5C3);
      chk("R11", "one pulse per strobe", pulses_s - p0, 1);

      // R4 long frame keeps last 16 bits
      send(32'hF1234, 20);
      chk("R4", "long frame word", code_i, 16'h1234);
      chk("R10", "long frame not short", short_i, 1'b0);
      strobe();

      // R5 short frame keeps stale bits
      send(32'hB, 4);
      chk("R5", "short frame word", code_i, 16'h234B);
      chk("R10", "short flag set", short_s, 1'b1);
      strobe();

      // R2 clock and data ignored while deselected
      p0 = pulses_i;
      for (int k = 0; k < 10; k++) begin
         sdi = k[0]; wait_clk(3); sclk = 1'b1; wait_clk(3); sclk = 1'b0;
      end
      wait_clk(4);
      chk("R2", "no update while deselected", pulses_i - p0, 0);
      send(32'h00, 8);
      chk("R2", "shift register untouched", code_i, 16'h4B00);
      chk("R10", "short flag still set", short_i, 1'b1);

      // R10 cleared by full frame
      send(32'h0F0F, 16);
      chk("R10", "short flag cleared", short_s, 1'b0);
      strobe();
      chk("R7", "strobe after clear", code_s, 16'h0F0F);

      // R9 strobe during frame
      frame_open();
      shift_bits(32'h55, 8);
      load_n = 1'b0; wait_clk(3); load_n = 1'b1; wait_clk(3);
      shift_bits(32'h55, 8);
      frame_close();
      chk("R9", "mid-frame strobe ignored", code_s, 16'h0F0F);
      chk("R9", "proto flag set", perr_s, 1'b1);
      chk("R3", "frame after bad strobe", code_i, 16'h5555);
      strobe();
      chk("R7", "strobe after error", code_s, 16'h5555);

      // R6 exact timing in immediate mode
      frame_open();
      shift_bits(32'h3C5A, 16);
      wait_clk(3);
      cs_n = 1'b1;
      wait_clk(2);
      chk("R6", "code before third edge", code_i, 16'h5555);
      wait_clk(1);
      chk("R6", "code at third edge", code_i, 16'h3C5A);
      chk("R11", "pulse with new code", upd_i, 1'b1);
      wait_clk(1);
      chk("R11", "pulse one cycle", upd_i, 1'b0);
      wait_clk(6);
      strobe();

      // R8 strobe held low
      load_n = 1'b0; wait_clk(8);
      send(32'h8001, 16);
      chk("R8", "held-low update", code_s, 16'h8001);
      load_n = 1'b1; wait_clk(8);
      chk("R8", "release no change", code_s, 16'h8001);

      // R7 exact strobe timing
      send(32'h7E81, 16);
      load_n = 1'b0;
      wait_clk(2);
      chk("R7", "strobe before third edge", code_s, 16'h8001);
      wait_clk(1);
      chk("R7", "strobe at third edge", code_s, 16'h7E81);
      chk("R11", "strobe pulse", upd_s, 1'b1);
      load_n = 1'b1; wait_clk(8);
      chk("R9", "proto flag sticky", perr_i, 1'b1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule